// File: doc/BRIEF.md
# Digital Output State Manager

This block owns a wide bank of on/off output channels and chooses which of four sources drives them. The sources are words written by the host, a set of power-up defaults kept in a nonvolatile store, the present values kept through a warm reset, and a set of safety values from the same store that take over when the watchdog fires. A host programs the store and reads it back through a staging buffer. Every store access takes a fixed, parameterised number of clock cycles, and a status bit shows when an access has finished.

The host reaches the block through a 16-bit word-addressed register port. Output words sit at 0x00 upward, and a read at those addresses returns the read-back snapshot. Staging words sit at 0x10 upward. The command register is at 0x20, the control register at 0x21 and the status register at 0x22. Control bit 0 holds the outputs across a warm reset, bit 1 enables the safety function and bit 2 enables the watchdog. Command codes are 1 for read-back start, 2 to program defaults from staging, 3 to program safety values from staging, 4 to fetch defaults into staging and 5 to fetch safety values into staging. Other codes do nothing. The nonvolatile store is modelled as registers that the cold reset does not clear.

Top module: `dout_state_mgr`

## Requirements
- R1: While rst_ni is low the outputs, the control register (0x21) and the status register (0x22) read zero.
- R2: After rst_ni rises the outputs stay zero for STORE_DELAY-1 clock edges and hold the stored defaults from the STORE_DELAY-th edge onward.
- R3: Writing word w at address w drives outputs 16w..16w+15 from the next edge, with bit value 1 meaning on. Such writes are ignored while a default load is pending.
- R4: With control bit 0 set, a warm reset pulse leaves the outputs unchanged.
- R5: With control bit 0 clear, a warm reset pulse turns every output off at the next edge and loads the stored defaults STORE_DELAY edges after the pulse.
- R6: A safety trigger loads the stored safety values onto the outputs at the next edge only when control bits 1 and 2 are both set. Otherwise it has no effect.
- R7: When a safety trigger and a host output write fall in the same cycle, the safety values win.
- R8: Command 1 clears status bit 1. RB_LAT edges later the bit is set again, and reads at the output addresses return the outputs captured at that point, unchanged by later output writes.
- R9: Commands 2 and 3 copy the staging words (0x10+w) into the stored defaults or the stored safety values. Status bit 0 is low for the STORE_DELAY cycles of the access and high again afterwards.
- R10: Commands 4 and 5 copy the stored defaults or safety values into the staging words after STORE_DELAY cycles. A store command that arrives while an access is running is ignored.
- R11: Status bits 2, 3 and 4 mirror control bits 1, 2 and 0 respectively. The control register changes only when it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Cold reset, asynchronous, active low |
| warm_rst_i | input | 1 | Warm reset pulse, synchronous |
| safety_trig_i | input | 1 | Watchdog expiry pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register word address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational on address |
| dout_o | output | NUM_WORDS*16 | Output channel states |

## Verification
A wrong selection between the output sources shows on dout_o at the first edge after the warm reset, trigger or write that caused it. A load or fetch that completes early or late shifts the change on dout_o, or the rise of status bit 0, by whole cycles. The bench sees this because it samples on every cycle of each access window. A read-back snapshot taken at the wrong time, or one that tracks the live outputs, shows up when the outputs are changed after status bit 1 rises and the snapshot is read again. Store contents are checked indirectly, through fetches into staging and through defaults and safety values arriving on dout_o.

// File: rtl/dom_pkg.sv
package dom_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OUT_BASE  = 6'h00;
  localparam logic [ADDR_W-1:0] STG_BASE  = 6'h10;
  localparam logic [ADDR_W-1:0] CMD_ADDR  = 6'h20;
  localparam logic [ADDR_W-1:0] CTL_ADDR  = 6'h21;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 6'h22;

  localparam logic [WORD_W-1:0] CMD_RB    = 16'h0001;
  localparam logic [WORD_W-1:0] CMD_PDEF  = 16'h0002;
  localparam logic [WORD_W-1:0] CMD_PSAFE = 16'h0003;
  localparam logic [WORD_W-1:0] CMD_FDEF  = 16'h0004;
  localparam logic [WORD_W-1:0] CMD_FSAFE = 16'h0005;

  // control bit positions
  localparam int unsigned CTL_HOLD = 0;
  localparam int unsigned CTL_SAFE = 1;
  localparam int unsigned CTL_WDT  = 2;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_LOAD,
    OP_PROG_DEF,
    OP_PROG_SAFE,
    OP_FETCH_DEF,
    OP_FETCH_SAFE
  } op_e;
endpackage

// File: rtl/dom_regs.sv
module dom_regs
  import dom_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 4,
  localparam int unsigned NUM_CH = NUM_WORDS * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic              fetch_we_i,
  input  logic [NUM_CH-1:0] fetch_data_i,
  input  logic              store_busy_i,
  input  logic              rb_ready_i,
  input  logic [NUM_CH-1:0] rb_data_i,
  output logic [NUM_CH-1:0] stg_o,
  output logic              hold_en_o,
  output logic              safe_en_o,
  output logic              wdt_en_o,
  output logic [NUM_WORDS-1:0] out_we_o,
  output logic              rb_start_o,
  output logic              op_start_o,
  output op_e               op_sel_o
);
  logic [NUM_CH-1:0] stg_q;
  logic [2:0]        ctl_q;
  logic              cmd_we;

  assign cmd_we = we_i && (addr_i == CMD_ADDR);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_out_we
    assign out_we_o[w] = we_i && (addr_i == OUT_BASE + 6'(w));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else if (fetch_we_i) begin
      stg_q <= fetch_data_i;
    end else begin
      for (int unsigned w = 0; w < NUM_WORDS; w++) begin
        if (we_i && addr_i == STG_BASE + 6'(w)) stg_q[w*WORD_W +: WORD_W] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           ctl_q <= '0;
    else if (we_i && addr_i == CTL_ADDR)   ctl_q <= wdata_i[2:0];
  end

  always_comb begin
    op_start_o = 1'b0;
    op_sel_o   = OP_IDLE;
    if (cmd_we) begin
      unique case (wdata_i)
        CMD_PDEF:  begin op_start_o = 1'b1; op_sel_o = OP_PROG_DEF;   end
        CMD_PSAFE: begin op_start_o = 1'b1; op_sel_o = OP_PROG_SAFE;  end
        CMD_FDEF:  begin op_start_o = 1'b1; op_sel_o = OP_FETCH_DEF;  end
        CMD_FSAFE: begin op_start_o = 1'b1; op_sel_o = OP_FETCH_SAFE; end
        default:   ;
      endcase
    end
  end

  assign rb_start_o = cmd_we && (wdata_i == CMD_RB);

  always_comb begin
    rdata_o = '0;
    for (int unsigned w = 0; w < NUM_WORDS; w++) begin
      if (addr_i == OUT_BASE + 6'(w)) rdata_o = rb_data_i[w*WORD_W +: WORD_W];
      if (addr_i == STG_BASE + 6'(w)) rdata_o = stg_q[w*WORD_W +: WORD_W];
    end
    if (addr_i == CTL_ADDR)  rdata_o = {13'b0, ctl_q};
    if (addr_i == STAT_ADDR) rdata_o = {11'b0, ctl_q[CTL_HOLD], ctl_q[CTL_WDT], ctl_q[CTL_SAFE],
                                        rb_ready_i, ~store_busy_i};
  end

  assign stg_o     = stg_q;
  assign hold_en_o = ctl_q[CTL_HOLD];
  assign safe_en_o = ctl_q[CTL_SAFE];
  assign wdt_en_o  = ctl_q[CTL_WDT];

  assert_ctl_write_only_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == CTL_ADDR) |=> $stable(ctl_q));
endmodule

// File: rtl/dom_store.sv
module dom_store
  import dom_pkg::*;
#(
  parameter int unsigned NUM_CH = 64,
  parameter int unsigned DELAY  = 16,
  localparam int unsigned CNT_W = (DELAY > 1) ? $clog2(DELAY) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_load_i,
  input  logic              cancel_load_i,
  input  logic              start_i,
  input  op_e               op_i,
  input  logic [NUM_CH-1:0] wr_data_i,
  output logic              busy_o,
  output logic              load_busy_o,
  output logic              load_done_o,
  output logic              fetch_we_o,
  output logic [NUM_CH-1:0] fetch_data_o,
  output logic [NUM_CH-1:0] def_q_o,
  output logic [NUM_CH-1:0] safe_q_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY - 1);

  op_e               op_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done;
  logic [NUM_CH-1:0] def_q, safe_q;

  assign busy_o       = (op_q != OP_IDLE);
  assign load_busy_o  = (op_q == OP_LOAD);
  assign done         = busy_o && (cnt_q == LAST) && !warm_load_i;
  assign load_done_o  = done && (op_q == OP_LOAD) && !cancel_load_i;
  assign fetch_we_o   = done && (op_q == OP_FETCH_DEF || op_q == OP_FETCH_SAFE);
  assign fetch_data_o = (op_q == OP_FETCH_SAFE) ? safe_q : def_q;

  // cold reset starts the power-up load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= OP_LOAD;
      cnt_q <= '0;
    end else if (warm_load_i) begin
      op_q  <= OP_LOAD;
      cnt_q <= '0;
    end else if (cancel_load_i && op_q == OP_LOAD) begin
      op_q  <= OP_IDLE;
      cnt_q <= '0;
    end else if (busy_o) begin
      if (cnt_q == LAST) begin
        op_q  <= OP_IDLE;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (start_i) begin
      op_q  <= op_i;
      cnt_q <= '0;
    end
  end

  // nonvolatile contents: untouched by cold reset
  always_ff @(posedge clk_i) begin
    if (done && op_q == OP_PROG_DEF)  def_q  <= wr_data_i;
    if (done && op_q == OP_PROG_SAFE) safe_q <= wr_data_i;
  end

  assign def_q_o  = def_q;
  assign safe_q_o = safe_q;

  assert_busy_ignores_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !warm_load_i && !cancel_load_i && cnt_q != LAST) |=> op_q == $past(op_q));

  assert_access_ends_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !cancel_load_i) |=> !busy_o);
endmodule

// File: rtl/dom_out.sv
module dom_out
  import dom_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned RB_LAT    = 2,
  localparam int unsigned NUM_CH = NUM_WORDS * WORD_W,
  localparam int unsigned RB_W   = (RB_LAT > 1) ? $clog2(RB_LAT) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_WORDS-1:0] out_we_i,
  input  logic [WORD_W-1:0]    wdata_i,
  input  logic                 load_busy_i,
  input  logic                 load_done_i,
  input  logic [NUM_CH-1:0]    def_i,
  input  logic                 safe_fire_i,
  input  logic [NUM_CH-1:0]    safe_i,
  input  logic                 warm_clear_i,
  input  logic                 warm_i,
  input  logic                 rb_start_i,
  output logic [NUM_CH-1:0]    dout_o,
  output logic [NUM_CH-1:0]    rb_data_o,
  output logic                 rb_ready_o
);
  localparam logic [RB_W-1:0] RB_LAST = RB_W'(RB_LAT - 1);

  logic [WORD_W-1:0] words_q [NUM_WORDS];

  // priority: warm clear, safety, default load, host write
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         words_q[w] <= '0;
      else if (warm_clear_i)               words_q[w] <= '0;
      else if (safe_fire_i)                words_q[w] <= safe_i[w*WORD_W +: WORD_W];
      else if (load_done_i)                words_q[w] <= def_i[w*WORD_W +: WORD_W];
      else if (!load_busy_i && out_we_i[w]) words_q[w] <= wdata_i;
    end
    assign dout_o[w*WORD_W +: WORD_W] = words_q[w];
  end

  logic            rb_busy_q;
  logic [RB_W-1:0] rb_cnt_q;
  logic [NUM_CH-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rb_busy_q  <= 1'b0;
      rb_cnt_q   <= '0;
      rb_ready_o <= 1'b0;
      snap_q     <= '0;
    end else if (warm_i) begin
      rb_busy_q  <= 1'b0;
      rb_cnt_q   <= '0;
      rb_ready_o <= 1'b0;
    end else if (rb_start_i) begin
      rb_busy_q  <= 1'b1;
      rb_cnt_q   <= '0;
      rb_ready_o <= 1'b0;
    end else if (rb_busy_q) begin
      if (rb_cnt_q == RB_LAST) begin
        rb_busy_q  <= 1'b0;
        rb_ready_o <= 1'b1;
        snap_q     <= dout_o;
      end else begin
        rb_cnt_q <= rb_cnt_q + 1'b1;
      end
    end
  end

  assign rb_data_o = snap_q;

  assert_warm_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_clear_i |=> dout_o == '0);

  assert_safety_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (safe_fire_i && !warm_clear_i) |=> dout_o == $past(safe_i));

  assert_load_ignores_host_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_busy_i && !load_done_i && !safe_fire_i && !warm_clear_i) |=> $stable(dout_o));

  assert_rb_start_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_start_i |=> !rb_ready_o);
endmodule

// File: rtl/dout_state_mgr.sv
module dout_state_mgr
  import dom_pkg::*;
#(
  parameter int unsigned NUM_WORDS   = 4,
  parameter int unsigned STORE_DELAY = 20,
  parameter int unsigned RB_LAT      = 2,
  localparam int unsigned NUM_CH = NUM_WORDS * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_rst_i,
  input  logic              safety_trig_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic [NUM_CH-1:0] dout_o
);
  logic [NUM_CH-1:0]    stg, fetch_data, def_q, safe_q, rb_data;
  logic [NUM_WORDS-1:0] out_we;
  logic hold_en, safe_en, wdt_en;
  logic fetch_we, store_busy, load_busy, load_done;
  logic rb_start, rb_ready, op_start;
  logic safe_fire, warm_clear;
  op_e  op_sel;

  assign safe_fire  = safety_trig_i && safe_en && wdt_en;
  assign warm_clear = warm_rst_i && !hold_en;

  dom_regs #(.NUM_WORDS(NUM_WORDS)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (reg_we_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .rdata_o      (reg_rdata_o),
    .fetch_we_i   (fetch_we),
    .fetch_data_i (fetch_data),
    .store_busy_i (store_busy),
    .rb_ready_i   (rb_ready),
    .rb_data_i    (rb_data),
    .stg_o        (stg),
    .hold_en_o    (hold_en),
    .safe_en_o    (safe_en),
    .wdt_en_o     (wdt_en),
    .out_we_o     (out_we),
    .rb_start_o   (rb_start),
    .op_start_o   (op_start),
    .op_sel_o     (op_sel)
  );

  dom_store #(.NUM_CH(NUM_CH), .DELAY(STORE_DELAY)) u_store (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .warm_load_i   (warm_clear),
    .cancel_load_i (safe_fire),
    .start_i       (op_start),
    .op_i          (op_sel),
    .wr_data_i     (stg),
    .busy_o        (store_busy),
    .load_busy_o   (load_busy),
    .load_done_o   (load_done),
    .fetch_we_o    (fetch_we),
    .fetch_data_o  (fetch_data),
    .def_q_o       (def_q),
    .safe_q_o      (safe_q)
  );

  dom_out #(.NUM_WORDS(NUM_WORDS), .RB_LAT(RB_LAT)) u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .out_we_i     (out_we),
    .wdata_i      (reg_wdata_i),
    .load_busy_i  (load_busy),
    .load_done_i  (load_done),
    .def_i        (def_q),
    .safe_fire_i  (safe_fire),
    .safe_i       (safe_q),
    .warm_clear_i (warm_clear),
    .warm_i       (warm_rst_i),
    .rb_start_i   (rb_start),
    .dout_o       (dout_o),
    .rb_data_o    (rb_data),
    .rb_ready_o   (rb_ready)
  );
endmodule

// File: tb/tb_dout_state_mgr.sv
`timescale 1ns/1ps
module tb_dout_state_mgr;
  localparam int NW  = 2;
  localparam int D   = 5;
  localparam int RBL = 2;
  localparam int NCH = NW * 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic warm_rst = 1'b0, trig = 1'b0;
  logic reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [NCH-1:0] dout;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dout_state_mgr #(.NUM_WORDS(NW), .STORE_DELAY(D), .RB_LAT(RBL)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .warm_rst_i(warm_rst), .safety_trig_i(trig),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .dout_o(dout)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr_out(input logic [31:0] v);
    wr(6'h00, v[15:0]); wr(6'h01, v[31:16]);
  endtask

  task automatic wr_stg(input logic [31:0] v);
    wr(6'h10, v[15:0]); wr(6'h11, v[31:16]);
  endtask

  task automatic rd_pair(input logic [5:0] base, output logic [31:0] v);
    logic [15:0] lo, hi;
    rd(base, lo); rd(base + 6'd1, hi);
    v = {hi, lo};
  endtask

  task automatic pulse_warm();
    warm_rst = 1'b1; @(posedge clk); @(negedge clk); warm_rst = 1'b0;
  endtask

  task automatic pulse_trig();
    trig = 1'b1; @(posedge clk); @(negedge clk); trig = 1'b0;
  endtask

  function automatic logic [31:0] pat(int k);
    return {16'(k * 16'h9e37) ^ 16'h5a5a, 16'(k * 16'h2b71) + 16'h0f0f};
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [31:0] v, a_def, b_safe, c_val;
    a_def  = 32'hA5C3_1E0F;
    b_safe = 32'h0FF0_9669;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "dout in reset", 64'(dout), 64'h0);
    rd(6'h21, r); chk("R1", "ctl in reset", 64'(r), 64'h0);
    rd(6'h22, r); chk("R1", "status in reset", 64'(r), 64'h0);
    @(negedge clk); rst_ni = 1'b1;
    for (int i = 0; i < 4 * D; i++) begin
      rd(6'h22, r);
      if (r[0]) break;
      @(negedge clk);
    end
    chk("R9", "initial load finished", 64'(r[0]), 64'h1);

    // R3: host writes, pattern sweep
    for (int k = 0; k < 12; k++) begin
      v = pat(k);
      wr(6'h00, v[15:0]);
      chk("R3", "word0 write", 64'(dout[15:0]), 64'(v[15:0]));
      wr(6'h01, v[31:16]);
      chk("R3", "word1 write", 64'(dout), 64'(v));
    end

    // R9: program defaults and safety values
    wr_stg(a_def);
    wr(6'h20, 16'h0002);
    rd(6'h22, r); chk("R9", "busy after program cmd", 64'(r[0]), 64'h0);
    repeat (D - 1) @(negedge clk);
    rd(6'h22, r); chk("R9", "busy at last cycle", 64'(r[0]), 64'h0);
    @(negedge clk);
    rd(6'h22, r); chk("R9", "done after delay", 64'(r[0]), 64'h1);
    wr_stg(b_safe);
    wr(6'h20, 16'h0003);
    repeat (D) @(negedge clk);
    rd(6'h22, r); chk("R9", "safety program done", 64'(r[0]), 64'h1);

    // R10: fetch, and ignore command while busy
    wr_stg(32'h0);
    wr(6'h20, 16'h0004);
    wr(6'h20, 16'h0005);
    repeat (D - 1) @(negedge clk);
    rd_pair(6'h10, v); chk("R10", "fetch defaults, busy cmd ignored", 64'(v), 64'(a_def));
    wr(6'h20, 16'h0005);
    repeat (D) @(negedge clk);
    rd_pair(6'h10, v); chk("R10", "fetch safety", 64'(v), 64'(b_safe));
    wr(6'h20, 16'h0007);
    rd(6'h22, r); chk("R10", "unknown cmd starts nothing", 64'(r[0]), 64'h1);

    // R2: cold reset reload, R3: write ignored during load
    wr(6'h21, 16'h0007);
    wr_out(32'h1234_5678);
    rst_ni = 1'b0; #1;
    chk("R1", "dout on cold reset", 64'(dout), 64'h0);
    @(negedge clk); rst_ni = 1'b1;
    wr(6'h00, 16'hFFFF);
    chk("R3", "write ignored during load", 64'(dout), 64'h0);
    for (int k = 2; k <= D; k++) begin
      @(negedge clk);
      chk("R2", "power-up load timing", 64'(dout), (k == D) ? 64'(a_def) : 64'h0);
    end
    rd(6'h21, r); chk("R1", "ctl cleared by cold reset", 64'(r), 64'h0);
    rd_pair(6'h10, v); chk("R1", "staging cleared by cold reset", 64'(v), 64'h0);

    // R4: hold through warm reset
    c_val = 32'hC0DE_7E57;
    wr(6'h21, 16'h0001);
    wr_out(c_val);
    pulse_warm();
    chk("R4", "hold at warm reset", 64'(dout), 64'(c_val));
    repeat (D + 1) @(negedge clk);
    chk("R4", "hold after warm reset", 64'(dout), 64'(c_val));

    // R5: warm reset without hold
    wr(6'h21, 16'h0000);
    pulse_warm();
    chk("R5", "off after warm reset", 64'(dout), 64'h0);
    for (int k = 1; k <= D; k++) begin
      @(negedge clk);
      chk("R5", "warm reload timing", 64'(dout), (k == D) ? 64'(a_def) : 64'h0);
    end

    // R6/R11: sweep all control values
    for (int c = 0; c < 8; c++) begin
      logic [2:0] cb;
      cb = 3'(c);
      wr(6'h21, 16'(c));
      v = pat(20 + c);
      wr_out(v);
      pulse_trig();
      chk("R6", $sformatf("trigger ctl=%0d", c), 64'(dout), (cb[1] && cb[2]) ? 64'(b_safe) : 64'(v));
      rd(6'h22, r);
      chk("R11", $sformatf("status mirror ctl=%0d", c), 64'(r[4:2]), 64'({cb[0], cb[2], cb[1]}));
    end

    // R7: safety beats host write in the same cycle
    wr(6'h21, 16'h0006);
    wr_out(c_val);
    reg_we = 1'b1; reg_addr = 6'h00; reg_wdata = 16'hFFFF; trig = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0; trig = 1'b0;
    chk("R7", "safety priority", 64'(dout), 64'(b_safe));

    // R8: read-back handshake and snapshot
    wr(6'h21, 16'h0000);
    v = pat(40);
    wr_out(v);
    wr(6'h20, 16'h0001);
    rd(6'h22, r); chk("R8", "ready cleared by start", 64'(r[1]), 64'h0);
    @(negedge clk);
    rd(6'h22, r); chk("R8", "not ready before latency", 64'(r[1]), 64'h0);
    @(negedge clk);
    rd(6'h22, r); chk("R8", "ready after latency", 64'(r[1]), 64'h1);
    rd_pair(6'h00, c_val); chk("R8", "read-back words", 64'(c_val), 64'(v));
    wr_out(pat(41));
    rd_pair(6'h00, c_val); chk("R8", "snapshot not live", 64'(c_val), 64'(v));
    wr(6'h20, 16'h0001);
    repeat (RBL) @(negedge clk);
    rd_pair(6'h00, c_val); chk("R8", "second read-back", 64'(c_val), 64'(pat(41)));

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule